// File: doc/BRIEF.md
# Floating-Point Error Interrupt Glue

This block sits on the board between a processor's active-low numeric-error output, the processor's active-low ignore-error input and one request line of a cascaded interrupt controller. It routes to request line 13 of the secondary controller. When the error line goes active, the block latches an interrupt request. The exception handler then writes to a fixed I/O port. That single write withdraws the request and, while the error is still pending, lets the processor run floating-point instructions by driving the ignore line active.

The ignore line is released by the error line itself. Once software clears the exception inside the floating-point unit and the error output goes inactive, the ignore output returns high with no further write. The handler may therefore clear the request latch and the unit's exception in either order, and the ignore line can never stay active outside the handler.

The error input crosses into the block's clock domain through a two-stage synchronizer before edge detection. Every register updates on the rising edge of one clock and is cleared by a synchronous active-high reset.

Top module: `fpu_err_glue`

## Requirements
- R1: While reset is high, and in the cycle after it, `irq_o` is 0 and `ign_n_o` is 1.
- R2: A high-to-low transition of `err_n_i` sets `irq_o` to 1. The new value is visible after the third rising clock edge following the transition: two synchronizer stages plus the request register.
- R3: A cycle with `io_wr_i` = 1 and `io_addr_i` = 0x00F0 clears `irq_o` at the next edge, unless a new error assertion is detected in the same cycle.
- R4: If the synchronized error is active, that same port 0x00F0 write drives `ign_n_o` to 0 at the next edge.
- R5: When `err_n_i` returns high, `ign_n_o` returns to 1 after the third rising edge, with no write. `ign_n_o` is never 0 unless the synchronized error was active in the previous cycle.
- R6: If the unit's exception is cleared before the request latch is cleared, `irq_o` stays 1 until the port write. That write then leaves `ign_n_o` at 1, and the final state matches the opposite order: `irq_o` = 0, `ign_n_o` = 1.
- R7: After `ign_n_o` has been released, a new assertion of `err_n_i` sets `irq_o` again.
- R8: A write to any address other than 0x00F0, a cycle with address 0x00F0 and `io_wr_i` = 0, and any value on `io_data_i` all leave `irq_o` and `ign_n_o` unchanged.
- R9: If an error assertion edge and a port 0x00F0 write are seen in the same cycle, the set wins: `irq_o` becomes 1, and `ign_n_o` becomes 0 because the error is active.
- R10: The request sets only on an assertion edge. A level that stays low after the request has been cleared does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| err_n_i | input | 1 | Active-low numeric-error line from the processor (asynchronous) |
| io_addr_i | input | ADDR_W (16) | I/O write address |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_data_i | input | DATA_W (8) | I/O write data, ignored |
| irq_o | output | 1 | Registered interrupt request to the controller |
| ign_n_o | output | 1 | Registered active-low ignore-error line to the processor |

## Verification
The two functions that can fall in one cycle are the setting of the request by a freshly synchronized error edge and its clearing by a port write. The bench provokes this by dropping the error line and placing the clear write exactly in the cycle in which the second synchronizer stage first shows the error. It then expects the request to stay high and the ignore line to go active together. A further case puts the write just after the error has been released, and the bench judges that the request clears without arming the ignore output.

// File: rtl/fpu_glue_pkg.sv
package fpu_glue_pkg;
  localparam int unsigned GLUE_ADDR_W   = 16;
  localparam int unsigned GLUE_DATA_W   = 8;
  localparam int unsigned GLUE_SYNC_LEN = 2;
  localparam logic [GLUE_ADDR_W-1:0] GLUE_CLR_PORT = 16'h00F0;

  // what one clocked cycle asks of the request flop
  typedef enum logic [1:0] {
    REQ_HOLD  = 2'd0,
    REQ_SET   = 2'd1,
    REQ_CLEAR = 2'd2
  } req_op_e;
endpackage

// File: rtl/fpu_err_sync.sv
module fpu_err_sync #(
  parameter int unsigned STAGES = fpu_glue_pkg::GLUE_SYNC_LEN
) (
  input  logic clk,
  input  logic rst,
  input  logic err_n_async,
  output logic err_lvl,   // active-high, synchronized
  output logic err_rise   // one cycle at start of assertion
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              lvl_d_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b1;
    else     chain_q[0] <= err_n_async;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b1;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign err_lvl = ~chain_q[LAST];

  always_ff @(posedge clk) begin
    if (rst) lvl_d_q <= 1'b0;
    else     lvl_d_q <= err_lvl;
  end

  assign err_rise = err_lvl & ~lvl_d_q;
endmodule

// File: rtl/fpu_port_decode.sv
module fpu_port_decode #(
  parameter int unsigned ADDR_W = fpu_glue_pkg::GLUE_ADDR_W,
  parameter int unsigned DATA_W = fpu_glue_pkg::GLUE_DATA_W,
  parameter logic [ADDR_W-1:0] CLR_PORT = ADDR_W'(fpu_glue_pkg::GLUE_CLR_PORT)
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_data,
  output logic              clr_hit
);
  logic data_unused;
  assign data_unused = ^io_data;
  assign clr_hit = io_wr && (io_addr == CLR_PORT);
endmodule

// File: rtl/fpu_req_latch.sv
module fpu_req_latch
  import fpu_glue_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic err_rise,
  input  logic clr_hit,
  output logic irq
);
  req_op_e op;
  logic    irq_q;

  // a new error edge outranks a clear in the same cycle
  always_comb begin
    if (err_rise)     op = REQ_SET;
    else if (clr_hit) op = REQ_CLEAR;
    else              op = REQ_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else begin
      unique case (op)
        REQ_SET:   irq_q <= 1'b1;
        REQ_CLEAR: irq_q <= 1'b0;
        default:   irq_q <= irq_q;
      endcase
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/fpu_ign_ctrl.sv
module fpu_ign_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic err_lvl,
  input  logic clr_hit,
  output logic ign_n
);
  logic ign_n_q;

  always_ff @(posedge clk) begin
    if (rst)           ign_n_q <= 1'b1;
    else if (!err_lvl) ign_n_q <= 1'b1;  // error gone: release
    else if (clr_hit)  ign_n_q <= 1'b0;  // handler entered
  end

  assign ign_n = ign_n_q;
endmodule

// File: rtl/fpu_err_glue.sv
module fpu_err_glue #(
  parameter int unsigned ADDR_W    = fpu_glue_pkg::GLUE_ADDR_W,
  parameter int unsigned DATA_W    = fpu_glue_pkg::GLUE_DATA_W,
  parameter int unsigned SYNC_LEN  = fpu_glue_pkg::GLUE_SYNC_LEN,
  parameter logic [ADDR_W-1:0] CLR_PORT = ADDR_W'(fpu_glue_pkg::GLUE_CLR_PORT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_n_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic [DATA_W-1:0] io_data_i,
  output logic              irq_o,
  output logic              ign_n_o
);
  logic err_lvl;
  logic err_rise;
  logic clr_hit;

  fpu_err_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk         (clk),
    .rst         (rst),
    .err_n_async (err_n_i),
    .err_lvl     (err_lvl),
    .err_rise    (err_rise)
  );

  fpu_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_PORT(CLR_PORT)) u_dec (
    .io_wr   (io_wr_i),
    .io_addr (io_addr_i),
    .io_data (io_data_i),
    .clr_hit (clr_hit)
  );

  fpu_req_latch u_req (
    .clk      (clk),
    .rst      (rst),
    .err_rise (err_rise),
    .clr_hit  (clr_hit),
    .irq      (irq_o)
  );

  fpu_ign_ctrl u_ign (
    .clk     (clk),
    .rst     (rst),
    .err_lvl (err_lvl),
    .clr_hit (clr_hit),
    .ign_n   (ign_n_o)
  );
endmodule

// File: rtl/fpu_err_glue_chk.sv
module fpu_err_glue_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] CLR_PORT = 16'h00F0
) (
  input logic              clk,
  input logic              rst,
  input logic              err_lvl,
  input logic              err_rise,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic              irq,
  input logic              ign_n
);
  AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    err_rise |=> irq); // R2
  AST_CLEAR_BY_PORT: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == CLR_PORT && !err_rise) |=> !irq); // R3
  AST_ARM_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == CLR_PORT && err_lvl) |=> !ign_n); // R4
  AST_RELEASE_IGNORE: assert property (@(posedge clk) disable iff (rst)
    !err_lvl |=> ign_n); // R5
  AST_IGNORE_NEEDS_ERR: assert property (@(posedge clk) disable iff (rst)
    !ign_n |-> $past(err_lvl)); // R5
  AST_OTHER_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(io_wr && io_addr == CLR_PORT) && !err_rise) |=> $stable(irq)); // R8
  AST_NO_LEVEL_SET: assert property (@(posedge clk) disable iff (rst)
    (!irq && !err_rise) |=> !irq); // R10
endmodule

bind fpu_err_glue fpu_err_glue_chk #(.ADDR_W(ADDR_W), .CLR_PORT(CLR_PORT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .err_lvl  (err_lvl),
  .err_rise (err_rise),
  .io_wr    (io_wr_i),
  .io_addr  (io_addr_i),
  .irq      (irq_o),
  .ign_n    (ign_n_o)
);

// File: tb/test_fpu_err_glue.sv
`timescale 1ns/1ps
module test_fpu_err_glue;
  logic        clk = 1'b0;
  logic        rst;
  logic        err_n;
  logic [15:0] addr;
  logic        wr;
  logic [7:0]  data;
  logic        irq;
  logic        ign_n;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  fpu_err_glue i_fpu_err_glue (
    .clk(clk), .rst(rst), .err_n_i(err_n), .io_addr_i(addr),
    .io_wr_i(wr), .io_data_i(data), .irq_o(irq), .ign_n_o(ign_n)
  );

  typedef struct packed {
    logic        err_n;
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [3:0]  cyc;
    logic        exp_irq;
    logic        exp_ign_n;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 16'h0000, 8'h00, 4'd2, 1'b0, 1'b1, 4'd1},  // R1 idle
    '{1'b0, 1'b0, 16'h0000, 8'h00, 4'd3, 1'b1, 1'b1, 4'd2},  // R2 set
    '{1'b0, 1'b1, 16'h00F0, 8'hA5, 4'd1, 1'b0, 1'b0, 4'd4},  // R3 R4
    '{1'b0, 1'b0, 16'h0000, 8'h00, 4'd3, 1'b0, 1'b0, 4'd10}, // R10 level held
    '{1'b1, 1'b0, 16'h0000, 8'h00, 4'd3, 1'b0, 1'b1, 4'd5},  // R5 release
    '{1'b0, 1'b0, 16'h0000, 8'h00, 4'd3, 1'b1, 1'b1, 4'd7},  // R7 again
    '{1'b0, 1'b0, 16'h00F0, 8'hFF, 4'd1, 1'b1, 1'b1, 4'd8},  // R8 no strobe
    '{1'b0, 1'b1, 16'h0070, 8'hF0, 4'd1, 1'b1, 1'b1, 4'd8},  // R8 other addr
    '{1'b1, 1'b0, 16'h0000, 8'h00, 4'd3, 1'b1, 1'b1, 4'd6},  // R6 fpu first
    '{1'b1, 1'b1, 16'h00F0, 8'h00, 4'd1, 1'b0, 1'b1, 4'd6},  // R6 latch last
    '{1'b1, 1'b0, 16'h0000, 8'h00, 4'd2, 1'b0, 1'b1, 4'd6}   // R6 settled
  };

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; err_n = 1'b1; addr = '0; wr = 1'b0; data = '0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", irq, 1'b0);
    check("R1 ign_n in reset", ign_n, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", irq, 1'b0);
    check("R1 ign_n after reset", ign_n, 1'b1);

    for (int i = 0; i < NV; i++) begin
      err_n = VEC[i].err_n;
      wr    = VEC[i].wr;
      addr  = VEC[i].addr;
      data  = VEC[i].data;
      repeat (int'(VEC[i].cyc)) @(negedge clk);
      wr = 1'b0;
      check($sformatf("R%0d vec%0d irq", VEC[i].req, i), irq, VEC[i].exp_irq);
      check($sformatf("R%0d vec%0d ign_n", VEC[i].req, i), ign_n, VEC[i].exp_ign_n);
    end

    // R9: clear write lands in the same cycle as the synchronized edge
    err_n = 1'b0;
    repeat (2) @(negedge clk);
    wr = 1'b1; addr = 16'h00F0;
    @(negedge clk);
    wr = 1'b0;
    check("R9 collision irq", irq, 1'b1);
    check("R9 collision ign_n", ign_n, 1'b0);

    // R6 order: latch cleared first, then the unit
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    check("R6 latch first irq", irq, 1'b0);
    check("R6 latch first ign_n", ign_n, 1'b0);
    err_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 unit second irq", irq, 1'b0);
    check("R6 unit second ign_n", ign_n, 1'b1);

    // R1: reset while the request is pending and ignore is active
    err_n = 1'b0;
    repeat (3) @(negedge clk);
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    err_n = 1'b0;
    check("R2 pre-reset set", ign_n, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid reset irq", irq, 1'b0);
    check("R1 mid reset ign_n", ign_n, 1'b1);
    err_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 quiet after reset irq", irq, 1'b0);
    check("R1 quiet after reset ign_n", ign_n, 1'b1);

    finish_run();
  end
endmodule